// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Sink Driver

This block turns a serial bit stream into eight sink-enable signals that switch low-side loads on and off. Bits enter on a serial data pin and move one stage per rising edge of a shift clock. A second, independent register clock copies the whole shift chain into a holding stage, so the loads change together rather than rippling while new data is shifted in. The holding stage drives the outputs through an enable gate.

An active-low clear empties every stage at once, without waiting for either clock. An active-low enable forces all loads off while it is high. The last shift stage leaves the block on a serial output that is re-timed on the falling shift-clock edge. Any number of these blocks can therefore share one shift clock in a daisy chain, and each downstream block sees data that is stable across its own rising edge.

Top module: `sdrv_out_driver`

## Requirements
- R1: On each rising edge of `sclk_i`, `sdata_i` enters stage 0 and every stage k takes the old value of stage k-1.
- R2: On each rising edge of `rclk_i`, the holding stage takes the shift-chain contents. The holding stage does not change at any other time except under clear.
- R3: While `clr_n_i` is low, the shift chain, the holding stage and `sdata_o` are all zero, whatever the clocks do. The clear acts without a clock edge.
- R4: While `oe_n_i` is high, every bit of `sink_en_o` is 0 (load off).
- R5: While `oe_n_i` is low, `sink_en_o` bit k equals holding bit k: 1 turns load k on and 0 turns it off.
- R6: `sdata_o` takes the value of the last stage (stage NBITS-1) on each falling edge of `sclk_i`.
- R7: The stage order is as follows. After NBITS shifts, the first bit shifted in sits at output NBITS-1. With two blocks chained (`sdata_o` of the first feeding `sdata_i` of the second) and 16 bits shifted most-significant first, the first block holds the low 8 bits of the word and the second block holds the high 8 bits, with word bit p at output p of the first block and word bit 8+p at output p of the second.
- R8: When `sclk_i` and `rclk_i` rise together, the holding stage takes the shift contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Shift clock; the chain moves on its rising edge |
| rclk_i | input | 1 | Register clock; the holding stage loads on its rising edge |
| clr_n_i | input | 1 | Asynchronous clear of every stage, active low |
| oe_n_i | input | 1 | Output enable, active low; high forces all loads off |
| sdata_i | input | 1 | Serial data in |
| sink_en_o | output | NBITS | Per-load sink enable, 1 = on |
| sdata_o | output | 1 | Cascade serial out, updated on the falling edge of `sclk_i` |

## Verification
A corrupted shift stage stays hidden until it reaches the ports. It appears on `sdata_o` within NBITS falling shift edges, or on `sink_en_o` after the next register-clock edge. The bench therefore checks the cascade output after every shift and compares both chained blocks against the shifted word. A bad holding stage appears on `sink_en_o` as soon as the enable is low. The bench checks the outputs before each register-clock pulse, so a holding stage that moved too early is reported at once. Clear and the coincident-edge case are checked right after the stimulus, before later shifts can overwrite the evidence.

// File: rtl/sdrv_pkg.sv
`timescale 1ns/1ps
package sdrv_pkg;

    localparam int unsigned DEF_NBITS = 8;

    typedef enum logic {
        SINK_OFF = 1'b0,
        SINK_ON  = 1'b1
    } sink_state_e;

    function automatic sink_state_e gate_sink(input logic enable_n, input logic held);
        return (!enable_n && held) ? SINK_ON : SINK_OFF;
    endfunction

endpackage

// File: rtl/sdrv_shift_chain.sv
`timescale 1ns/1ps
module sdrv_shift_chain #(
    parameter int unsigned NBITS = sdrv_pkg::DEF_NBITS
) (
    input  logic             sclk_i,
    input  logic             clr_n_i,
    input  logic             sdata_i,
    output logic [NBITS-1:0] stages_o
);

    localparam int unsigned TOP = NBITS - 1;

    always_ff @(posedge sclk_i or negedge clr_n_i) begin
        if (!clr_n_i) begin
            stages_o <= '0;
        end else begin
            stages_o <= {stages_o[TOP-1:0], sdata_i};
        end
    end

endmodule

// File: rtl/sdrv_hold_bank.sv
`timescale 1ns/1ps
module sdrv_hold_bank #(
    parameter int unsigned NBITS = sdrv_pkg::DEF_NBITS
) (
    input  logic             rclk_i,
    input  logic             clr_n_i,
    input  logic [NBITS-1:0] load_i,
    output logic [NBITS-1:0] held_o
);

    always_ff @(posedge rclk_i or negedge clr_n_i) begin
        if (!clr_n_i) begin
            held_o <= '0;
        end else begin
            held_o <= load_i;
        end
    end

endmodule

// File: rtl/sdrv_tail_retime.sv
`timescale 1ns/1ps
module sdrv_tail_retime (
    input  logic sclk_i,
    input  logic clr_n_i,
    input  logic last_i,
    output logic tail_o
);

    always_ff @(negedge sclk_i or negedge clr_n_i) begin
        if (!clr_n_i) begin
            tail_o <= 1'b0;
        end else begin
            tail_o <= last_i;
        end
    end

endmodule

// File: rtl/sdrv_out_driver.sv
`timescale 1ns/1ps
module sdrv_out_driver #(
    parameter int unsigned NBITS = sdrv_pkg::DEF_NBITS
) (
    input  logic             sclk_i,
    input  logic             rclk_i,
    input  logic             clr_n_i,
    input  logic             oe_n_i,
    input  logic             sdata_i,
    output logic [NBITS-1:0] sink_en_o,
    output logic             sdata_o
);

    import sdrv_pkg::*;

    localparam int unsigned LAST = NBITS - 1;

    logic [NBITS-1:0] shift_q;
    logic [NBITS-1:0] store_q;

    sdrv_shift_chain #(.NBITS(NBITS)) chain_i (
        .sclk_i   (sclk_i),
        .clr_n_i  (clr_n_i),
        .sdata_i  (sdata_i),
        .stages_o (shift_q)
    );

    sdrv_hold_bank #(.NBITS(NBITS)) hold_i (
        .rclk_i  (rclk_i),
        .clr_n_i (clr_n_i),
        .load_i  (shift_q),
        .held_o  (store_q)
    );

    sdrv_tail_retime tail_i (
        .sclk_i  (sclk_i),
        .clr_n_i (clr_n_i),
        .last_i  (shift_q[LAST]),
        .tail_o  (sdata_o)
    );

    for (genvar g = 0; g < NBITS; g++) begin : g_gate
        sink_state_e lane_state;
        always_comb begin
            lane_state   = gate_sink(oe_n_i, store_q[g]);
            sink_en_o[g] = (lane_state == SINK_ON);
        end
    end

endmodule

// File: rtl/sdrv_out_driver_chk.sv
`timescale 1ns/1ps
module sdrv_out_driver_chk #(
    parameter int unsigned NBITS = sdrv_pkg::DEF_NBITS
) (
    input logic             sclk_i,
    input logic             rclk_i,
    input logic             clr_n_i,
    input logic             oe_n_i,
    input logic             sdata_i,
    input logic [NBITS-1:0] shift_q,
    input logic [NBITS-1:0] store_q,
    input logic [NBITS-1:0] sink_en_o,
    input logic             sdata_o
);

    // Each flag is set by the first edge of its clock after a clear and is wiped by the clear.
    logic rise_seen, rclk_seen, fall_seen;

    always_ff @(posedge sclk_i or negedge clr_n_i) begin
        if (!clr_n_i) rise_seen <= 1'b0;
        else          rise_seen <= 1'b1;
    end

    always_ff @(posedge rclk_i or negedge clr_n_i) begin
        if (!clr_n_i) rclk_seen <= 1'b0;
        else          rclk_seen <= 1'b1;
    end

    always_ff @(negedge sclk_i or negedge clr_n_i) begin
        if (!clr_n_i) fall_seen <= 1'b0;
        else          fall_seen <= 1'b1;
    end

    assert_shift_step_R1: assert property (@(posedge sclk_i) disable iff (!clr_n_i)
        rise_seen |-> (shift_q[0] == $past(sdata_i)) &&
                      (shift_q[NBITS-1:1] == $past(shift_q[NBITS-2:0])));

    assert_hold_load_R2: assert property (@(posedge rclk_i) disable iff (!clr_n_i)
        rclk_seen |-> (store_q == $past(shift_q)));

    assert_clear_wipe_R3: assert property (@(posedge sclk_i)
        !clr_n_i |-> (shift_q == '0) && (store_q == '0) && (sdata_o == 1'b0));

    assert_disable_off_R4: assert property (@(posedge sclk_i)
        oe_n_i |-> (sink_en_o == '0));

    assert_tail_fall_R6: assert property (@(negedge sclk_i) disable iff (!clr_n_i)
        fall_seen |-> (sdata_o == $past(shift_q[NBITS-1])));

endmodule

bind sdrv_out_driver sdrv_out_driver_chk #(.NBITS(NBITS)) chk_i (
    .sclk_i    (sclk_i),
    .rclk_i    (rclk_i),
    .clr_n_i   (clr_n_i),
    .oe_n_i    (oe_n_i),
    .sdata_i   (sdata_i),
    .shift_q   (shift_q),
    .store_q   (store_q),
    .sink_en_o (sink_en_o),
    .sdata_o   (sdata_o)
);

// File: tb/sdrv_out_driver_tb_top.sv
`timescale 1ns/1ps
module sdrv_out_driver_tb_top;

    localparam int CLK_PERIOD = 100;
    localparam int NB = 8;

    logic          sclk, rclk, clr_n, oe_n, sdata;
    logic [NB-1:0] sink_a, sink_b;
    logic          link, tail_b;

    int n_checks = 0;
    int n_fail   = 0;

    sdrv_out_driver #(.NBITS(NB)) dut_i (
        .sclk_i(sclk), .rclk_i(rclk), .clr_n_i(clr_n), .oe_n_i(oe_n),
        .sdata_i(sdata), .sink_en_o(sink_a), .sdata_o(link)
    );

    sdrv_out_driver #(.NBITS(NB)) dut_b (
        .sclk_i(sclk), .rclk_i(rclk), .clr_n_i(clr_n), .oe_n_i(oe_n),
        .sdata_i(link), .sink_en_o(sink_b), .sdata_o(tail_b)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Data is set 25 ns before the rising edge and held until 25 ns after the falling edge.
    task automatic shift_bit(input logic b, input logic with_rclk);
        sdata = b;
        #(CLK_PERIOD/4);
        sclk = 1'b1;
        if (with_rclk) rclk = 1'b1;
        #(CLK_PERIOD/2);
        sclk = 1'b0;
        rclk = 1'b0;
        #(CLK_PERIOD/4);
    endtask

    task automatic pulse_rclk();
        #(CLK_PERIOD/4);
        rclk = 1'b1;
        #(CLK_PERIOD/2);
        rclk = 1'b0;
        #(CLK_PERIOD/4);
    endtask

    // Shifts the word most-significant bit first and checks the cascade tap after every shift.
    task automatic load16(input logic [15:0] w);
        for (int k = 0; k < 16; k++) begin
            shift_bit(w[15-k], 1'b0);
            if (k >= 7) check("R6 tail", {15'd0, link}, {15'd0, w[15-(k-7)]});
        end
    endtask

    function automatic logic [15:0] pattern(input int idx);
        if (idx < 16) return 16'(1) << idx;
        case (idx)
            16:      return 16'h0000;
            17:      return 16'hFFFF;
            18:      return 16'hA55A;
            default: return 16'h3C96;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] prev;
        logic [15:0] w;
        sclk = 0; rclk = 0; clr_n = 0; oe_n = 0; sdata = 0;
        #(CLK_PERIOD);
        check("R3 reset sinks", {sink_b, sink_a}, 16'h0000);
        check("R3 reset tail", {15'd0, link}, 16'h0000);
        clr_n = 1;
        #(CLK_PERIOD);
        prev = 16'h0000;

        // R1 R2 R5 R7: sweep of chained words
        for (int idx = 0; idx < 20; idx++) begin
            w = pattern(idx);
            load16(w);
            check("R2 hold before rclk", {sink_b, sink_a}, prev);
            pulse_rclk();
            check("R1 R7 first block", {8'd0, sink_a}, {8'd0, w[7:0]});
            check("R7 second block",   {8'd0, sink_b}, {8'd0, w[15:8]});
            prev = w;
        end

        // R4 and R5: enable gating keeps the holding stage
        oe_n = 1;
        #(CLK_PERIOD/4);
        check("R4 disabled", {sink_b, sink_a}, 16'h0000);
        shift_bit(1'b1, 1'b0);
        check("R4 disabled after shift", {sink_b, sink_a}, 16'h0000);
        oe_n = 0;
        #(CLK_PERIOD/4);
        check("R5 re-enabled", {sink_b, sink_a}, prev);

        // R8: coincident rising edges capture the pre-edge chain
        w = 16'hC3A5;
        load16(w);
        pulse_rclk();
        shift_bit(1'b1, 1'b1);
        check("R8 coincident edge", {8'd0, sink_a}, {8'd0, w[7:0]});
        pulse_rclk();
        check("R1 after extra shift", {8'd0, sink_a}, {8'd0, w[6:0], 1'b1});

        // R3: clear during operation, with a shift edge while held
        clr_n = 0;
        #(CLK_PERIOD/4);
        check("R3 async clear sinks", {sink_b, sink_a}, 16'h0000);
        shift_bit(1'b1, 1'b1);
        check("R3 clear dominates", {sink_b, sink_a}, 16'h0000);
        check("R3 clear tail", {15'd0, link}, 16'h0000);
        clr_n = 1;
        #(CLK_PERIOD/4);
        pulse_rclk();
        check("R3 chain emptied", {sink_b, sink_a}, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule